// File: doc/BRIEF.md
# Row-Distributed Matched-Filter Correlator

This block forms the correlation between a stored received vector and every column of a stored signature matrix. Each column stands for one path delay. The matrix is split by row across a set of lanes. A lane keeps one or more received samples, and for each of them the signature values for every delay. A central sequencer steps through the delays, one per clock. On each step every lane reads the values for the current delay and multiplies them by its samples. A lane that holds more than one row adds its own products together first. A fully pipelined adder tree then reduces the lane results to one correlation.

Loading is done through two write ports while the block is idle: one for received samples and one for signature values. A single `start` pulse then sweeps all delays. The results leave the block as a stream of (delay index, correlation, valid) in increasing delay order, one per cycle. Because the tree is pipelined, the reductions for successive delays overlap inside it. The lane count is the number of samples divided by the rows per lane, rounded up. The tree pads a lane count that is not a power of two with zero leaves.

Top module: `mf_row_correlator`

## Requirements
- R1: After reset, `out_valid` is low and stays low until `start` is accepted.
- R2: An accepted `start` issues every delay from 0 to N_DLY-1 exactly once, in increasing order. The results leave on consecutive cycles, with `out_delay` holding the delay each result belongs to.
- R3: `out_corr` for delay d is the sum over all samples n of sample[n] times coef[n][d]. Every operand is signed two's complement of DW bits. The sum is kept in full precision with no wrap, so it covers every operand sign and extreme, including -128 times -128.
- R4: The result for delay d has `out_valid` high right after the clock edge that comes 2 + ceil(log2(LANES)) + d edges after the edge that samples `start`.
- R5: `start` is ignored while a sweep is issuing, and this includes the edge at which the last delay is handed on. It is accepted one edge later. Back-to-back sweeps therefore leave one idle output cycle between them.
- R6: Sample n is held in lane n / ROWS_PER_LANE (rounded down). Each lane adds its rows together before the tree. Rows past the last sample, and tree leaves past the last lane, add zero.
- R7: A sample write with `rx_row` >= N_SAMP, or a signature write with `co_row` >= N_SAMP or `co_dly` >= N_DLY, changes no stored value.
- R8: Values written while idle persist, and they take effect on the next sweep. Writing one sample changes only that sample's contribution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Pulse that begins a sweep over all delays |
| rx_we | input | 1 | Write strobe for a received sample |
| rx_row | input | clog2(N_SAMP) | Sample index to write |
| rx_data | input | DW | Signed sample value |
| co_we | input | 1 | Write strobe for a signature value |
| co_row | input | clog2(N_SAMP) | Sample (row) index of the signature value |
| co_dly | input | clog2(N_DLY) | Delay (column) index of the signature value |
| co_data | input | DW | Signed signature value |
| out_valid | output | 1 | A correlation is present on this cycle |
| out_delay | output | clog2(N_DLY) | Delay index of the correlation |
| out_corr | output | CORR_W | Signed correlation, full precision |

## Verification
On every cycle, the assertions check how the sequencer steps: it never issues while idle, it moves up by exactly one, and it stops after the last delay. They also check that results leave in strictly consecutive delay order, that the first delay of a sweep is 0, and that no delay index is out of range. Only the bench scenarios can show the correlation values, the exact latency and the grouping of rows into lanes. The same holds for the zero padding, the discarding of out-of-range writes and the one-cycle gap between back-to-back sweeps. The bench compares each of these against sums it computes itself over several data patterns, including an impulse placed on every sample in turn.

// File: rtl/mf_pkg.sv
`timescale 1ns/1ps
package mf_pkg;

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int idx_w(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  function automatic int tree_depth(input int leaves);
    return (leaves <= 1) ? 0 : $clog2(leaves);
  endfunction

  // width of one lane result: product plus growth of the local row sum
  function automatic int lane_w(input int dw, input int rows);
    return 2 * dw + ((rows <= 1) ? 0 : $clog2(rows));
  endfunction

  // rows that really hold a sample in a given lane
  function automatic int live_rows(input int nsamp, input int rows, input int lane);
    int left;
    left = nsamp - lane * rows;
    return (left < rows) ? left : rows;
  endfunction

endpackage

// File: rtl/mf_issue_ctl.sv
`timescale 1ns/1ps
module mf_issue_ctl #(
  parameter int N_DLY = 32,
  parameter int XW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          iss_vld,
  output logic [XW-1:0] iss_idx
);
  localparam logic [XW-1:0] LAST = XW'(N_DLY - 1);

  logic at_last;
  logic accept;
  assign at_last = iss_vld && (iss_idx == LAST);
  assign accept  = start && !iss_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iss_vld <= 1'b0;
      iss_idx <= '0;
    end else if (accept) begin
      iss_vld <= 1'b1;
      iss_idx <= '0;
    end else if (at_last) begin
      iss_vld <= 1'b0;
    end else if (iss_vld) begin
      iss_idx <= iss_idx + XW'(1);
    end
  end

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!iss_vld && !start) |=> !iss_vld);

  assert_issue_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_vld && iss_idx != LAST) |=> (iss_vld && iss_idx == $past(iss_idx) + XW'(1)));

  assert_stop_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    at_last |=> !iss_vld);

endmodule

// File: rtl/mf_lane.sv
`timescale 1ns/1ps
module mf_lane #(
  parameter int DW    = 8,
  parameter int SAW   = 7,
  parameter int XW    = 5,
  parameter int N_DLY = 32,
  parameter int BASE  = 0,
  parameter int LIVE  = 2,
  parameter int PW    = 17
) (
  input  logic                 clk,
  input  logic                 rx_we,
  input  logic [SAW-1:0]       rx_row,
  input  logic signed [DW-1:0] rx_data,
  input  logic                 co_we,
  input  logic [SAW-1:0]       co_row,
  input  logic [XW-1:0]        co_dly,
  input  logic signed [DW-1:0] co_data,
  input  logic                 rd_en,
  input  logic [XW-1:0]        rd_dly,
  input  logic                 mac_en,
  output logic signed [PW-1:0] lane_sum
);
  logic signed [DW-1:0] samp_q [LIVE];
  logic signed [DW-1:0] cmem   [LIVE][N_DLY];
  logic signed [DW-1:0] coef_q [LIVE];
  logic signed [PW-1:0] part;

  // local row decode: which of this lane's rows a write targets
  logic rx_hit, co_hit;
  int   rx_sel, co_sel;

  function automatic logic signed [PW-1:0] mul_ext(input logic signed [DW-1:0] a,
                                                   input logic signed [DW-1:0] b);
    return PW'(a) * PW'(b);
  endfunction

  always_comb begin
    rx_sel = int'(rx_row) - BASE;
    co_sel = int'(co_row) - BASE;
    rx_hit = rx_we && (rx_sel >= 0) && (rx_sel < LIVE);
    co_hit = co_we && (co_sel >= 0) && (co_sel < LIVE) && (int'(co_dly) < N_DLY);
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < LIVE; r++) begin
      if (rx_hit && rx_sel == r) samp_q[r] <= rx_data;
      if (co_hit && co_sel == r) cmem[r][co_dly] <= co_data;
    end
  end

  // read stage: the signature values of the current delay for every local row
  always_ff @(posedge clk) begin
    if (rd_en) begin
      for (int r = 0; r < LIVE; r++) coef_q[r] <= cmem[r][rd_dly];
    end
  end

  // multiply stage with local pre-accumulation of this lane's rows
  always_comb begin
    part = '0;
    for (int r = 0; r < LIVE; r++) part = part + mul_ext(samp_q[r], coef_q[r]);
  end

  always_ff @(posedge clk) begin
    if (mac_en) lane_sum <= part;
  end

endmodule

// File: rtl/mf_adder_tree.sv
`timescale 1ns/1ps
module mf_adder_tree #(
  parameter  int LEAVES = 44,
  parameter  int IW     = 17,
  parameter  int XW     = 5,
  localparam int DEPTH  = mf_pkg::tree_depth(LEAVES),
  localparam int OW     = IW + DEPTH,
  localparam int PAD    = 1 << DEPTH
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic [XW-1:0]        in_idx,
  input  logic signed [IW-1:0] in_leaf [LEAVES],
  output logic                 out_vld,
  output logic [XW-1:0]        out_idx,
  output logic signed [OW-1:0] out_sum
);

  for (genvar l = 0; l <= DEPTH; l++) begin : g_lvl
    localparam int W  = IW + l;
    localparam int NN = PAD >> l;
    logic signed [W-1:0] node [NN];
    logic                vld;
    logic [XW-1:0]       idx;

    if (l == 0) begin : g_leaf
      for (genvar i = 0; i < NN; i++) begin : g_pad
        if (i < LEAVES) begin : g_live
          assign node[i] = in_leaf[i];
        end else begin : g_zero
          assign node[i] = '0;
        end
      end
      assign vld = in_vld;
      assign idx = in_idx;
    end else begin : g_add
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld <= 1'b0;
        else        vld <= g_lvl[l-1].vld;
      end
      always_ff @(posedge clk) begin
        if (g_lvl[l-1].vld) begin
          idx <= g_lvl[l-1].idx;
          for (int i = 0; i < NN; i++)
            node[i] <= W'(g_lvl[l-1].node[2*i]) + W'(g_lvl[l-1].node[2*i+1]);
        end
      end
    end
  end

  assign out_vld = g_lvl[DEPTH].vld;
  assign out_idx = g_lvl[DEPTH].idx;
  assign out_sum = g_lvl[DEPTH].node[0];

  assert_tree_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && $past(out_vld)) |-> (out_idx == $past(out_idx) + XW'(1)));

endmodule

// File: rtl/mf_row_correlator.sv
`timescale 1ns/1ps
module mf_row_correlator #(
  parameter  int N_SAMP        = 88,
  parameter  int ROWS_PER_LANE = 2,
  parameter  int N_DLY         = 32,
  parameter  int DW            = 8,
  localparam int LANES         = mf_pkg::ceil_div(N_SAMP, ROWS_PER_LANE),
  localparam int SAW           = mf_pkg::idx_w(N_SAMP),
  localparam int XW            = mf_pkg::idx_w(N_DLY),
  localparam int PW            = mf_pkg::lane_w(DW, ROWS_PER_LANE),
  localparam int CORR_W        = PW + mf_pkg::tree_depth(LANES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     rx_we,
  input  logic [SAW-1:0]           rx_row,
  input  logic signed [DW-1:0]     rx_data,
  input  logic                     co_we,
  input  logic [SAW-1:0]           co_row,
  input  logic [XW-1:0]            co_dly,
  input  logic signed [DW-1:0]     co_data,
  output logic                     out_valid,
  output logic [XW-1:0]            out_delay,
  output logic signed [CORR_W-1:0] out_corr
);
  // named internal events
  logic          iss_vld;
  logic [XW-1:0] iss_idx;
  logic          rd_vld;
  logic [XW-1:0] rd_idx;
  logic          mac_vld;
  logic [XW-1:0] mac_idx;
  logic signed [PW-1:0] leaf [LANES];

  mf_issue_ctl #(.N_DLY(N_DLY), .XW(XW)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .iss_vld (iss_vld),
    .iss_idx (iss_idx)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int BASE = g * ROWS_PER_LANE;
    localparam int LIVE = mf_pkg::live_rows(N_SAMP, ROWS_PER_LANE, g);
    mf_lane #(
      .DW(DW), .SAW(SAW), .XW(XW), .N_DLY(N_DLY),
      .BASE(BASE), .LIVE(LIVE), .PW(PW)
    ) u_lane (
      .clk      (clk),
      .rx_we    (rx_we),
      .rx_row   (rx_row),
      .rx_data  (rx_data),
      .co_we    (co_we),
      .co_row   (co_row),
      .co_dly   (co_dly),
      .co_data  (co_data),
      .rd_en    (iss_vld),
      .rd_dly   (iss_idx),
      .mac_en   (rd_vld),
      .lane_sum (leaf[g])
    );
  end

  // valid and delay index travelling beside the lane read and multiply stages
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld  <= 1'b0;
      mac_vld <= 1'b0;
    end else begin
      rd_vld  <= iss_vld;
      mac_vld <= rd_vld;
    end
  end

  always_ff @(posedge clk) begin
    rd_idx  <= iss_idx;
    mac_idx <= rd_idx;
  end

  mf_adder_tree #(.LEAVES(LANES), .IW(PW), .XW(XW)) u_tree (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (mac_vld),
    .in_idx  (mac_idx),
    .in_leaf (leaf),
    .out_vld (out_valid),
    .out_idx (out_delay),
    .out_sum (out_corr)
  );

  assert_delay_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_delay) < N_DLY));

  assert_sweep_begins_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(out_valid)) |-> (out_delay == '0));

endmodule

// File: tb/mf_row_correlator_tb.sv
`timescale 1ns/1ps
module mf_row_correlator_tb;
  localparam int NS  = 11;
  localparam int RPL = 2;
  localparam int ND  = 5;
  localparam int DW  = 8;
  localparam int LN  = (NS + RPL - 1) / RPL;
  localparam int DEP = $clog2(LN);
  localparam int LAT = 2 + DEP;
  localparam int SAW = $clog2(NS);
  localparam int XW  = $clog2(ND);
  localparam int CW  = 2 * DW + $clog2(RPL) + DEP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic rx_we = 1'b0;
  logic [SAW-1:0] rx_row = '0;
  logic signed [DW-1:0] rx_data = '0;
  logic co_we = 1'b0;
  logic [SAW-1:0] co_row = '0;
  logic [XW-1:0] co_dly = '0;
  logic signed [DW-1:0] co_data = '0;
  logic out_valid;
  logic [XW-1:0] out_delay;
  logic signed [CW-1:0] out_corr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int rx_m [NS];
  int co_m [NS][ND];

  always #2.5 clk = ~clk;

  mf_row_correlator #(.N_SAMP(NS), .ROWS_PER_LANE(RPL), .N_DLY(ND), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rx_we(rx_we), .rx_row(rx_row), .rx_data(rx_data),
    .co_we(co_we), .co_row(co_row), .co_dly(co_dly), .co_data(co_data),
    .out_valid(out_valid), .out_delay(out_delay), .out_corr(out_corr)
  );

  function automatic int s8(input int v);
    int m;
    m = ((v % 256) + 256) % 256;
    return (m >= 128) ? m - 256 : m;
  endfunction

  function automatic int expect_corr(input int d);
    int acc = 0;
    for (int n = 0; n < NS; n++) acc += rx_m[n] * co_m[n][d];
    return acc;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // all write tasks start and end at a falling edge
  task automatic wr_rx(input int n, input int v);
    rx_we = 1'b1; rx_row = SAW'(n); rx_data = DW'(v);
    @(negedge clk);
    rx_we = 1'b0;
    if (n < NS) rx_m[n] = s8(v);
  endtask

  task automatic wr_co(input int n, input int d, input int v);
    co_we = 1'b1; co_row = SAW'(n); co_dly = XW'(d); co_data = DW'(v);
    @(negedge clk);
    co_we = 1'b0;
    if (n < NS && d < ND) co_m[n][d] = s8(v);
  endtask

  // pulse start, then watch every cycle; xj = cycle of an extra start pulse (-1 none)
  task automatic run_sweep(input string ctag, input string vtag,
                           input int xj, input bit second);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j <= LAT + 2 * ND + 4; j++) begin
      int d1 = j - LAT;
      int d2 = j - (LAT + ND + 1);
      bit ev = 1'b0;
      int ed = 0;
      if (d1 >= 0 && d1 < ND) begin ev = 1'b1; ed = d1; end
      else if (second && d2 >= 0 && d2 < ND) begin ev = 1'b1; ed = d2; end
      chk(out_valid == ev, vtag, "out_valid", int'(out_valid), int'(ev));
      if (ev && out_valid) begin
        chk(int'(out_delay) == ed, "R2", "out_delay", int'(out_delay), ed);
        chk(int'(out_corr) == expect_corr(ed), ctag, "out_corr",
            int'(out_corr), expect_corr(ed));
      end
      start = (j == xj);
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic load_all(input int kind, input int seed);
    bit [31:0] st = 32'(seed);
    for (int n = 0; n < NS; n++) begin
      int v;
      if (kind == 0) v = n * 13 - 70;
      else if (kind == 1) v = -128;
      else if (kind == 2) v = 127;
      else begin st = st * 32'd1103515245 + 32'd12345; v = int'(st[23:16]); end
      wr_rx(n, v);
      for (int d = 0; d < ND; d++) begin
        int c;
        if (kind == 0) c = (n * 29 + d * 53 + 7) % 256 - 128;
        else if (kind == 1 || kind == 2) c = -128;
        else begin st = st * 32'd1103515245 + 32'd12345; c = int'(st[23:16]); end
        wr_co(n, d, c);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: quiet through and after reset
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    end
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "out_valid idle", int'(out_valid), 0);
    end

    // R3 R4 R6: ramp pattern
    load_all(0, 1);
    run_sweep("R3", "R4", -1, 1'b0);

    // R3: extreme operands, no wrap
    load_all(1, 1);
    run_sweep("R3", "R4", -1, 1'b0);
    load_all(2, 1);
    run_sweep("R3", "R4", -1, 1'b0);

    // R3: pseudo-random operands
    load_all(3, 7);
    run_sweep("R3", "R4", -1, 1'b0);
    load_all(3, 99);
    run_sweep("R3", "R4", -1, 1'b0);

    // R7: out-of-range writes are discarded
    load_all(0, 1);
    for (int n = NS; n < (1 << SAW); n++) begin
      wr_rx(n, 99);
      for (int d = 0; d < (1 << XW); d++) wr_co(n, d, 77);
    end
    for (int n = 0; n < NS; n++)
      for (int d = ND; d < (1 << XW); d++) wr_co(n, d, 55);
    run_sweep("R7", "R4", -1, 1'b0);

    // R6 R8: impulse on each sample in turn, rewritten between sweeps
    for (int n = 0; n < NS; n++) wr_rx(n, 0);
    for (int n = 0; n < NS; n++) begin
      wr_rx(n, n - 4 + ((n == 4) ? 9 : 0));
      run_sweep("R6", "R4", -1, 1'b0);
      wr_rx(n, 0);
      run_sweep("R8", "R4", -1, 1'b0);
    end

    // R5: start pulses during a sweep are ignored, including on the last issue
    load_all(3, 5);
    run_sweep("R5", "R5", 0, 1'b0);
    run_sweep("R5", "R5", 1, 1'b0);
    run_sweep("R5", "R5", ND - 1, 1'b0);
    // R5 R4: earliest accepted restart gives a second sweep after one idle cycle
    run_sweep("R5", "R4", ND, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule